// File: doc/BRIEF.md
# UART Receive Status and Error Unit

This block is the receive half of a UART. It samples an asynchronous RX line sixteen times per bit, using a one-cycle baud tick from outside. It assembles characters least significant bit first and checks the optional parity bit and the stop bit. A separate counter watches for a line held low for longer than a whole frame. An optional ninth-bit mode serves multidrop RS-485 links, where a set ninth bit marks an address character.

Every received character goes into a receive FIFO. The FIFO depth is a parameter, 16 or 64 entries. The host reaches the block through three word addresses. Address 0 returns the oldest stored byte and removes it. Address 1 returns the status word: sticky error flags that are cleared by writing 1, live FIFO empty and full bits, and the byte count. Address 2 holds the address-enable control bit. Hardware sets this bit when an address character arrives, and the host can write it.

Top module: `uart_rx_status`

## Requirements
- R1: The FIFO count (status bits [15:8]) rises by one for every stored character and falls by one for every host read of address 0 while the FIFO is not empty.
- R2: The full bit (status bit 6) is 1 exactly when the count equals the FIFO depth.
- R3: The empty bit (status bit 5) is 1 after reset. It is set when the host reads the last stored byte and is cleared when a new character is stored.
- R4: A character that arrives while the FIFO holds its full depth, with no host read in the same cycle, is discarded and sets the overflow flag (status bit 4). The stored bytes and the count stay unchanged.
- R5: The break flag (status bit 2) is set once the RX line has stayed low for more than 16 ticks times the frame length. The frame length is 1 start bit, 8 data bits, 1 extra bit when parity or ninth-bit mode is on, and 1 stop bit. A character that is low for less than this time does not set the flag.
- R6: A stop bit sampled as 0 sets the framing error flag (status bit 1).
- R7: With parity on and ninth-bit mode off, the parity bit follows the data bits. With `cfg_par_odd`=0 the data bits plus the parity bit must hold an even number of ones; with `cfg_par_odd`=1 they must hold an odd number. A mismatch sets the parity error flag (status bit 0).
- R8: In ninth-bit mode the bit after the 8 data bits is the ninth bit. When it is 1, the address flag (status bit 3) is set and the address-enable bit (address 2, bit 0) is set. The host can write the address-enable bit directly.
- R9: Writing 1 to a status bit in positions 0 to 4 clears that flag. Writing 0 leaves it unchanged.
- R10: A low pulse on RX that is high again by the middle of the start bit (8th tick) is ignored: nothing is stored and no flag changes.
- R11: If a flag is set by an event in the same cycle as a write of 1 to that flag, the flag ends up set.
- R12: Bytes read from address 0 come out in arrival order. Each byte is assembled least significant bit first and occupies bits [7:0] of the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| rx_i | input | 1 | Serial receive line, idle high |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_ninth | input | 1 | Ninth-bit (RS-485 address) mode |
| reg_addr | input | 2 | Register address: 0 data, 1 status, 2 address enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 0) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current address |
| addr_en_o | output | 1 | Address-enable control bit |

## Verification
The hardest case to reach is the collision in which a flag-setting event and a host write of 1 to the same flag land in the same cycle. The event's cycle depends on the oversampling phase and on the synchronizer delay. To hit it without predicting that cycle, the bench sends a character with bad parity and writes 1 to the parity flag on every cycle. It stops writing on the first cycle in which the count shows the character stored. The boundary of the break detector is the other delicate case. The bench compares an all-zero character that has a valid stop bit, which stays just under the threshold, with a line held low for twelve bit times.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int OVS   = 16;
  localparam int OVS_W = $clog2(OVS);
  localparam int REG_W = 16;

  // status bit positions
  localparam int F_PE   = 0;
  localparam int F_FE   = 1;
  localparam int F_BRK  = 2;
  localparam int F_ADR  = 3;
  localparam int F_OVF  = 4;
  localparam int NFLAGS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  // number of bit times in one character frame
  function automatic int frame_bits(input int data_bits, input int extra);
    return 1 + data_bits + extra + 1;
  endfunction

  // ticks that one frame lasts at OVS samples per bit
  function automatic int frame_ticks(input int data_bits, input int extra);
    return OVS * frame_bits(data_bits, extra);
  endfunction

  // running xor of data bits combined with the received parity bit
  function automatic logic parity_ok(input logic data_xor, input logic par_bit,
                                     input logic odd);
    return (data_xor ^ par_bit) == odd;
  endfunction

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx_i,
  input  logic                 cfg_par_en,
  input  logic                 cfg_par_odd,
  input  logic                 cfg_ninth,
  output logic                 rx_s_o,
  output logic                 char_vld_o,
  output logic [DATA_BITS-1:0] char_data_o,
  output logic                 char_ninth_o,
  output logic                 char_perr_o,
  output logic                 char_ferr_o
);

  localparam int IW = $clog2(DATA_BITS + 2);
  localparam logic [OVS_W-1:0] HALF = OVS_W'(OVS / 2 - 1);
  localparam logic [OVS_W-1:0] FULL = OVS_W'(OVS - 1);

  logic [1:0]           sync_q;
  rx_state_e            state_q;
  logic [OVS_W-1:0]     os_q;
  logic [IW-1:0]        idx_q;
  logic [DATA_BITS-1:0] sh_q;
  logic                 xor_q, ninth_q, perr_q, ferr_q, vld_q;

  logic rx_s, has_extra, last_bit_w, glitch_w;

  assign rx_s       = sync_q[1];
  assign has_extra  = cfg_par_en | cfg_ninth;
  assign last_bit_w = has_extra ? (idx_q == IW'(DATA_BITS))
                                : (idx_q == IW'(DATA_BITS - 1));
  assign glitch_w   = (state_q == ST_START) && tick && (os_q == HALF) && rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      state_q <= ST_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      xor_q   <= 1'b0;
      ninth_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      vld_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (tick && !rx_s) begin
            state_q <= ST_START;
            os_q    <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (os_q == HALF) begin
              if (rx_s) begin
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_BITS;
                os_q    <= '0;
                idx_q   <= '0;
                xor_q   <= 1'b0;
                perr_q  <= 1'b0;
                ninth_q <= 1'b0;
              end
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
        end
        ST_BITS: begin
          if (tick) begin
            os_q <= os_q + 1'b1;
            if (os_q == FULL) begin
              if (idx_q < IW'(DATA_BITS)) begin
                sh_q  <= {rx_s, sh_q[DATA_BITS-1:1]};
                xor_q <= xor_q ^ rx_s;
              end else begin
                ninth_q <= cfg_ninth & rx_s;
                perr_q  <= cfg_par_en & ~cfg_ninth &
                           ~parity_ok(xor_q, rx_s, cfg_par_odd);
              end
              idx_q <= idx_q + 1'b1;
              if (last_bit_w) state_q <= ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            os_q <= os_q + 1'b1;
            if (os_q == FULL) begin
              vld_q   <= 1'b1;
              ferr_q  <= ~rx_s;
              state_q <= rx_s ? ST_IDLE : ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (rx_s) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rx_s_o       = rx_s;
  assign char_vld_o   = vld_q;
  assign char_data_o  = sh_q;
  assign char_ninth_o = ninth_q;
  assign char_perr_o  = perr_q;
  assign char_ferr_o  = ferr_q;

  // R10: a start that is high again at mid-bit is dropped without a character
  assert_glitch_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_w |=> (state_q == ST_IDLE) && !vld_q);

  // R6: the framing result matches the line level sampled at mid stop bit
  assert_ferr_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (ferr_q == !$past(rx_s)));

endmodule

// File: rtl/uart_rx_break.sv
module uart_rx_break
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_s,
  input  logic cfg_extra,
  output logic brk_o
);

  localparam int LIM_MAX = frame_ticks(DATA_BITS, 1);
  localparam int CW      = $clog2(LIM_MAX + 2);

  logic [CW-1:0] lim_w, cnt_q;
  logic          brk_q;

  assign lim_w = CW'(frame_ticks(DATA_BITS, int'(cfg_extra)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      brk_q <= 1'b0;
    end else begin
      brk_q <= 1'b0;
      if (rx_s) begin
        cnt_q <= '0;
      end else if (tick && (cnt_q <= lim_w)) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == lim_w) brk_q <= 1'b1;
      end
    end
  end

  assign brk_o = brk_q;

  // R5: a break only follows low samples
  assert_brk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> !$past(rx_s));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       ovf_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          empty_q;
  logic          full_w, accept_w, do_pop_w, ovf_w;

  assign full_w   = (cnt_q == CW'(DEPTH));
  assign do_pop_w = pop && (cnt_q != '0);
  assign accept_w = push && (!full_w || do_pop_w);
  assign ovf_w    = push && full_w && !do_pop_w;

  always_ff @(posedge clk) begin
    if (accept_w) mem_q[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      empty_q <= 1'b1;
    end else begin
      if (accept_w) wr_q <= wr_q + 1'b1;
      if (do_pop_w) rd_q <= rd_q + 1'b1;
      case ({accept_w, do_pop_w})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (accept_w) empty_q <= 1'b0;
      else if (do_pop_w && (cnt_q == CW'(1))) empty_q <= 1'b1;
    end
  end

  assign dout  = mem_q[rd_q];
  assign count = cnt_q;
  assign full  = full_w;
  assign empty = empty_q;
  assign ovf_o = ovf_w;

  // R1: a stored character without a read raises the count by one
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !do_pop_w) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3: the sticky empty bit agrees with an empty count
  assert_empty_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q == (cnt_q == '0));

  // R4: a discarded character leaves the count alone
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_w |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DATA_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             rx_i,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_ninth,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             addr_en_o
);

  localparam int CW = $clog2(DEPTH + 1);

  logic                 rx_s, char_vld, char_ninth, char_perr, char_ferr, brk_w;
  logic [DATA_BITS-1:0] char_data, fifo_dout;
  logic [CW-1:0]        fifo_cnt;
  logic                 fifo_full, fifo_empty, ovf_w, pop_w;

  logic                 perr_evt, ferr_evt, addr_evt;
  logic [NFLAGS-1:0]    set_w, clr_w, flags_q;
  logic                 addr_en_q;

  uart_rx_deser #(.DATA_BITS(DATA_BITS)) u_deser (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (baud_tick),
    .rx_i         (rx_i),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_odd  (cfg_par_odd),
    .cfg_ninth    (cfg_ninth),
    .rx_s_o       (rx_s),
    .char_vld_o   (char_vld),
    .char_data_o  (char_data),
    .char_ninth_o (char_ninth),
    .char_perr_o  (char_perr),
    .char_ferr_o  (char_ferr)
  );

  uart_rx_break #(.DATA_BITS(DATA_BITS)) u_break (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .rx_s      (rx_s),
    .cfg_extra (cfg_par_en | cfg_ninth),
    .brk_o     (brk_w)
  );

  assign pop_w = reg_rd && (reg_addr == 2'd0);

  uart_rx_fifo #(.DEPTH(DEPTH), .W(DATA_BITS)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (char_vld),
    .din   (char_data),
    .pop   (pop_w),
    .dout  (fifo_dout),
    .count (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty),
    .ovf_o (ovf_w)
  );

  assign perr_evt = char_vld && char_perr;
  assign ferr_evt = char_vld && char_ferr;
  assign addr_evt = char_vld && cfg_ninth && char_ninth;

  always_comb begin
    set_w        = '0;
    set_w[F_PE]  = perr_evt;
    set_w[F_FE]  = ferr_evt;
    set_w[F_BRK] = brk_w;
    set_w[F_ADR] = addr_evt;
    set_w[F_OVF] = ovf_w;
  end

  assign clr_w = (reg_wr && (reg_addr == 2'd1)) ? reg_wdata[NFLAGS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      addr_en_q <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_w) | set_w;
      if (addr_evt) addr_en_q <= 1'b1;
      else if (reg_wr && (reg_addr == 2'd2)) addr_en_q <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[DATA_BITS-1:0] = fifo_dout;
      2'd1: begin
        reg_rdata[NFLAGS-1:0] = flags_q;
        reg_rdata[5]          = fifo_empty;
        reg_rdata[6]          = fifo_full;
        reg_rdata[15:8]       = 8'(fifo_cnt);
      end
      2'd2: reg_rdata[0] = addr_en_q;
      default: reg_rdata = '0;
    endcase
  end

  assign addr_en_o = addr_en_q;

  // R11: a set coinciding with a clear leaves the flag set
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt |=> flags_q[F_PE]);

  // R9: writing 1 clears a flag that no event is setting
  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w[F_FE] && !ferr_evt) |=> !flags_q[F_FE]);

  // R9: writing 0 keeps a set flag
  assert_zero_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == 2'd1) && !reg_wdata[F_PE] && flags_q[F_PE])
      |=> flags_q[F_PE]);

  // R8: an address character raises the address enable
  assert_addr_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_evt |=> addr_en_q && flags_q[F_ADR]);

  // R2: the full indication is consistent with the count
  assert_full_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> (fifo_cnt == CW'(DEPTH)) && !fifo_empty);

endmodule

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;

  localparam int DEPTH   = 16;
  localparam int TDIV    = 4;
  localparam int BIT_CLK = 16 * TDIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_tick = 1'b0;
  logic        rx_i = 1'b1;
  logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_ninth = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        addr_en_o;

  int checks = 0;
  int errors = 0;
  int tdiv_cnt = 0;
  bit done = 0;

  uart_rx_status #(.DEPTH(DEPTH), .DATA_BITS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_i(rx_i),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_ninth(cfg_ninth),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_en_o(addr_en_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv_cnt  <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    baud_tick <= (tdiv_cnt == TDIV - 1);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pop(output logic [7:0] v);
    @(negedge clk);
    reg_addr = 2'd0;
    reg_rd   = 1'b1;
    #1 v = reg_rdata[7:0];
    @(negedge clk);
    reg_rd   = 1'b0;
    reg_addr = 2'd1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
    reg_addr  = 2'd1;
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk);
    rx_i = b;
    repeat (BIT_CLK - 1) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input logic has_x,
                           input logic xbit, input logic stopb);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (has_x) drive_bit(xbit);
    drive_bit(stopb);
    drive_bit(1'b1);
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic drain();
    logic [15:0] s;
    logic [7:0]  b;
    peek(2'd1, s);
    for (int i = 0; i < 80 && s[15:8] != 0; i++) begin
      pop(b);
      peek(2'd1, s);
    end
    wr(2'd1, 16'h001F);
  endtask

  task automatic t_reset();
    logic [15:0] s;
    peek(2'd1, s);
    chk(s == 16'h0020, "R3 reset status empty only", s, 16'h0020);
    peek(2'd2, s);
    chk(s == 16'h0000, "R8 reset address enable", s, 0);
  endtask

  task automatic t_basic();
    logic [15:0] s;
    logic [7:0]  b;
    send_char(8'hA5, 1'b0, 1'b0, 1'b1);
    send_char(8'h3C, 1'b0, 1'b0, 1'b1);
    peek(2'd1, s);
    chk(s[15:8] == 2, "R1 count after two chars", s[15:8], 2);
    chk(s[5] == 0, "R3 empty cleared on receive", s[5], 0);
    chk(s[4:0] == 0, "R6 clean chars raise no flag", s[4:0], 0);
    pop(b);
    chk(b == 8'hA5, "R12 first byte", b, 8'hA5);
    peek(2'd1, s);
    chk(s[15:8] == 1 && s[5] == 0, "R1 count after one read", s[15:8], 1);
    pop(b);
    chk(b == 8'h3C, "R12 second byte", b, 8'h3C);
    peek(2'd1, s);
    chk(s[15:8] == 0 && s[5] == 1, "R3 empty set on last read", s, 16'h0020);
    pop(b);
    peek(2'd1, s);
    chk(s[15:8] == 0 && s[5] == 1, "R1 read of empty FIFO keeps count", s[15:8], 0);
  endtask

  task automatic t_parity();
    logic [15:0] s;
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_char(8'h5A, 1'b1, par_of(8'h5A, 1'b0), 1'b1);
    peek(2'd1, s);
    chk(s[0] == 0, "R7 even parity correct", s[0], 0);
    send_char(8'h07, 1'b1, ~par_of(8'h07, 1'b0), 1'b1);
    peek(2'd1, s);
    chk(s[0] == 1, "R7 even parity wrong", s[0], 1);
    wr(2'd1, 16'h001E);
    peek(2'd1, s);
    chk(s[0] == 1, "R9 writing 0 keeps parity flag", s[0], 1);
    wr(2'd1, 16'h0001);
    peek(2'd1, s);
    chk(s[0] == 0, "R9 writing 1 clears parity flag", s[0], 0);
    cfg_par_odd = 1'b1;
    send_char(8'h07, 1'b1, par_of(8'h07, 1'b1), 1'b1);
    peek(2'd1, s);
    chk(s[0] == 0, "R7 odd parity correct", s[0], 0);
    send_char(8'h10, 1'b1, ~par_of(8'h10, 1'b1), 1'b1);
    peek(2'd1, s);
    chk(s[0] == 1, "R7 odd parity wrong", s[0], 1);
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    drain();
  endtask

  task automatic t_framing();
    logic [15:0] s;
    logic [7:0]  b;
    send_char(8'h81, 1'b0, 1'b0, 1'b0);
    peek(2'd1, s);
    chk(s[1] == 1, "R6 stop bit 0 sets framing flag", s[1], 1);
    chk(s[2] == 0, "R5 short low does not break", s[2], 0);
    pop(b);
    chk(b == 8'h81, "R12 byte with framing error stored", b, 8'h81);
    wr(2'd1, 16'h0002);
    peek(2'd1, s);
    chk(s[1] == 0, "R9 framing flag cleared", s[1], 0);
    drain();
  endtask

  task automatic t_break();
    logic [15:0] s;
    send_char(8'h00, 1'b0, 1'b0, 1'b1);
    peek(2'd1, s);
    chk(s[2] == 0, "R5 zero char below frame time", s[2], 0);
    @(negedge clk);
    rx_i = 1'b0;
    repeat (12 * BIT_CLK) @(negedge clk);
    rx_i = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    peek(2'd1, s);
    chk(s[2] == 1, "R5 long low sets break", s[2], 1);
    chk(s[1] == 1, "R6 long low ends with bad stop", s[1], 1);
    drain();
  endtask

  task automatic t_glitch();
    logic [15:0] s;
    @(negedge clk);
    rx_i = 1'b0;
    repeat (5 * TDIV) @(negedge clk);
    rx_i = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    peek(2'd1, s);
    chk(s == 16'h0020, "R10 glitch ignored", s, 16'h0020);
  endtask

  task automatic t_ninth();
    logic [15:0] s;
    cfg_ninth = 1'b1;
    send_char(8'h42, 1'b1, 1'b0, 1'b1);
    peek(2'd1, s);
    chk(s[3] == 0 && addr_en_o == 0, "R8 data char no address", s[3], 0);
    send_char(8'h17, 1'b1, 1'b1, 1'b1);
    peek(2'd1, s);
    chk(s[3] == 1, "R8 address flag set", s[3], 1);
    peek(2'd2, s);
    chk(s[0] == 1, "R8 address enable set", s[0], 1);
    wr(2'd2, 16'h0000);
    peek(2'd2, s);
    chk(s[0] == 0, "R8 address enable written", s[0], 0);
    cfg_ninth = 1'b0;
    drain();
  endtask

  task automatic t_setwins();
    logic [15:0] s;
    cfg_par_en = 1'b1;
    fork
      send_char(8'h33, 1'b1, ~par_of(8'h33, 1'b0), 1'b1);
      begin
        @(negedge clk);
        reg_addr  = 2'd1;
        reg_wdata = 16'h0001;
        reg_wr    = 1'b1;
        for (int i = 0; i < 2000; i++) begin
          @(negedge clk);
          #1;
          if (reg_rdata[15:8] != 0) break;
        end
        reg_wr = 1'b0;
      end
    join
    peek(2'd1, s);
    chk(s[0] == 1, "R11 set wins over clear", s[0], 1);
    cfg_par_en = 1'b0;
    drain();
  endtask

  task automatic t_overflow();
    logic [15:0] s;
    logic [7:0]  b;
    for (int i = 0; i < DEPTH; i++) send_char(8'(8'h10 + i), 1'b0, 1'b0, 1'b1);
    peek(2'd1, s);
    chk(s[6] == 1 && s[15:8] == DEPTH, "R2 full at depth", s, DEPTH);
    chk(s[4] == 0, "R4 no overflow at depth", s[4], 0);
    send_char(8'hEE, 1'b0, 1'b0, 1'b1);
    peek(2'd1, s);
    chk(s[4] == 1, "R4 overflow flag set", s[4], 1);
    chk(s[15:8] == DEPTH, "R4 count unchanged on overflow", s[15:8], DEPTH);
    pop(b);
    chk(b == 8'h10, "R4 oldest byte kept", b, 8'h10);
    peek(2'd1, s);
    chk(s[6] == 0 && s[15:8] == DEPTH - 1, "R2 full drops after read", s[15:8], DEPTH - 1);
    for (int i = 1; i < DEPTH; i++) begin
      pop(b);
      chk(b == 8'(8'h10 + i), "R4 contents unchanged", b, 8'h10 + i);
    end
    peek(2'd1, s);
    chk(s[5] == 1 && s[15:8] == 0, "R3 empty after drain", s, 16'h0030);
    drain();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_framing();
    t_break();
    t_glitch();
    t_ninth();
    t_setwins();
    t_overflow();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule